// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the horizontal and vertical raster position for a 240x160 LCD panel whose timing domain is larger than its visible area: 308 dots per line and 228 lines per frame. A prescaler advances the dot position once every four system clocks, so one scanline lasts 1232 clocks and one frame lasts 1232 x 228 clocks. From the position the block derives the horizontal-blank, vertical-blank and line-match flags and brings out the current line number.

Software reaches the block through a small register port. Address 0 is a packed status/control word. Its low bits report the three live flags and hold three interrupt enables. Its upper byte holds a compare line. Address 1 returns the current line number. For each enabled condition the block emits a one-clock interrupt request pulse when that condition becomes true. Downstream rendering, memory fetch and arbitration use these outputs but are not part of the block.

Top module: `raster_timer`

## Requirements
- R1: The dot position advances once every DOT_DIV (default 4) clocks. After reset, the first advance happens on the DOT_DIV-th clock edge, so a line lasts H_TOTAL x DOT_DIV clocks (1232 by default).
- R2: `in_hblank` is low while the dot position is 0 to H_VIS-1 (0..239) and high for H_VIS to H_TOTAL-1 (240..307). The dot position wraps to 0 after H_TOTAL-1.
- R3: The line number advances by one only when the dot position wraps. It counts 0 to V_TOTAL-1 (0..227) and then returns to 0.
- R4: `in_vblank` is high for lines V_VIS to V_TOTAL-1 (160..227) and low for lines 0 to V_VIS-1. It clears when the line number wraps to 0.
- R5: The current line number appears on `scanline`, and on `reg_rdata` (zero-extended) when `reg_addr` is 1.
- R6: When `reg_addr` is 0, `reg_rdata` returns the status word. Bit 0 is vblank, bit 1 is hblank, bit 2 is line match, bit 3 enables the vblank request, bit 4 enables the hblank request, bit 5 enables the match request, bits 7:6 read 0 and bits 15:8 hold the compare line. `line_match` and bit 2 are high exactly while the line number equals the compare line.
- R7: A write (`reg_wr` high with `reg_addr` 0) updates only bits 5:3 and 15:8, taking effect after the clock edge. Bits 2:0 and 7:6 ignore written data. A write with `reg_addr` 1 changes nothing.
- R8: Each request output pulses high for exactly one clock, in the first clock in which its condition is true while its enable bit is set. A condition that is already high produces no further pulse, and no pulse occurs while the enable is clear.
- R9: Reset (synchronous, `rst_n` low) returns the line and dot position to 0, clears the enables and the compare line, and holds all request outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 status/control, 1 line number |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| scanline | output | $clog2(V_TOTAL) | Current line number |
| in_hblank | output | 1 | Dot position is in horizontal blank |
| in_vblank | output | 1 | Line number is in vertical blank |
| line_match | output | 1 | Line number equals the compare line |
| irq_vblank | output | 1 | One-clock vblank request |
| irq_hblank | output | 1 | One-clock hblank request |
| irq_match | output | 1 | One-clock line-match request |

## Verification
The embedded assertions check properties that must hold on every cycle. The dot tick is never high on two consecutive clocks. The dot position stays in range and holds between ticks. The line number moves only on a dot wrap. Every request is a single-clock pulse that comes with its live condition. Only the bench scenarios can show the exact cycle counts, the enable gating, the status bit layout, the ignored flag bits after a write, and a match edge caused by rewriting the compare line. For these, a reduced-size instance is compared against a behavioural model on every clock. A default-size instance is also checked at the 960-clock hblank edge and the 1232-clock line boundary.

// File: rtl/raster_pkg.sv
// Package: shared field positions of the raster timer register word.
// Assumes a 16-bit register port and a compare line of at most 8 bits.
package raster_pkg;
    localparam int REG_W    = 16;
    localparam int CMP_W    = 8;
    localparam int CMP_LSB  = 8;
    localparam int B_VBL    = 0;
    localparam int B_HBL    = 1;
    localparam int B_MATCH  = 2;
    localparam int B_EN_VBL = 3;
    localparam int B_EN_HBL = 4;
    localparam int B_EN_MAT = 5;

    typedef struct packed {
        logic match;
        logic hbl;
        logic vbl;
    } irq_en_t;
endpackage

// File: rtl/raster_dot_div.sv
// Module: dot prescaler. Issues one dot_tick every DIV clocks, starting on the
// DIV-th clock after reset. Assumes DIV >= 1.
module raster_dot_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic dot_tick
);
    generate
        if (DIV == 1) begin : g_nodiv
            assign dot_tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;

            // Count system clocks modulo DIV.
            always_ff @(posedge clk) begin
                if (!rst_n)                        cnt <= '0;
                else if (cnt == CW'(DIV - 1))      cnt <= '0;
                else                               cnt <= cnt + 1'b1;
            end

            assign dot_tick = (cnt == CW'(DIV - 1));

            // R1: ticks are spaced, never back to back
            a_r1_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
                dot_tick |=> !dot_tick);
        end
    endgenerate
endmodule

// File: rtl/raster_counters.sv
// Module: horizontal dot and vertical line counters with blank flags.
// Assumes dot_tick marks the single clock in which the dot position advances.
module raster_counters #(
    parameter int H_TOTAL = 308,
    parameter int H_VIS   = 240,
    parameter int V_TOTAL = 228,
    parameter int V_VIS   = 160,
    localparam int HW     = $clog2(H_TOTAL),
    localparam int VW     = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dot_tick,
    output logic [HW-1:0] hpos,
    output logic [VW-1:0] vpos,
    output logic          in_hblank,
    output logic          in_vblank
);
    logic h_last;
    logic v_last;

    assign h_last = (hpos == HW'(H_TOTAL - 1));
    assign v_last = (vpos == VW'(V_TOTAL - 1));

    // Advance the dot position on each tick, wrapping at the end of the line.
    always_ff @(posedge clk) begin
        if (!rst_n)        hpos <= '0;
        else if (dot_tick) hpos <= h_last ? '0 : hpos + 1'b1;
    end

    // Advance the line number when the dot position wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)                 vpos <= '0;
        else if (dot_tick && h_last) vpos <= v_last ? '0 : vpos + 1'b1;
    end

    assign in_hblank = (hpos >= HW'(H_VIS));
    assign in_vblank = (vpos >= VW'(V_VIS));

    // R2: dot position stays inside the line
    a_r2_h_range: assert property (@(posedge clk) disable iff (!rst_n)
        hpos <= HW'(H_TOTAL - 1));
    // R1: dot position holds between ticks
    a_r1_h_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_tick |=> $stable(hpos));
    // R3: line number moves only at a dot wrap
    a_r3_v_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(dot_tick && hpos == HW'(H_TOTAL - 1)) |=> $stable(vpos));
    // R3: line number stays inside the frame
    a_r3_v_range: assert property (@(posedge clk) disable iff (!rst_n)
        vpos <= VW'(V_TOTAL - 1));
endmodule

// File: rtl/raster_status.sv
// Module: status/control word, line compare and edge-triggered request pulses.
// Assumes the flags come from registered counters, so each is glitch-free.
module raster_status
    import raster_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic [VW-1:0]    vpos,
    input  logic             in_hblank,
    input  logic             in_vblank,
    output logic [REG_W-1:0] status,
    output logic             line_match,
    output logic             irq_vblank,
    output logic             irq_hblank,
    output logic             irq_match
);
    irq_en_t          en;
    logic [CMP_W-1:0] cmp_line;
    logic             vbl_d, hbl_d, mat_d;

    // Capture writable fields; flag bits are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= '0;
            cmp_line <= '0;
        end else if (wr_en) begin
            en.vbl   <= wdata[B_EN_VBL];
            en.hbl   <= wdata[B_EN_HBL];
            en.match <= wdata[B_EN_MAT];
            cmp_line <= wdata[CMP_LSB +: CMP_W];
        end
    end

    assign line_match = (CMP_W'(vpos) == cmp_line);

    // Remember last-cycle conditions for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbl_d <= 1'b0;
            hbl_d <= 1'b0;
            mat_d <= 1'b0;
        end else begin
            vbl_d <= in_vblank;
            hbl_d <= in_hblank;
            mat_d <= line_match;
        end
    end

    assign irq_vblank = en.vbl   && in_vblank  && !vbl_d;
    assign irq_hblank = en.hbl   && in_hblank  && !hbl_d;
    assign irq_match  = en.match && line_match && !mat_d;

    // Assemble the readable word.
    always_comb begin
        status                       = '0;
        status[B_VBL]                = in_vblank;
        status[B_HBL]                = in_hblank;
        status[B_MATCH]              = line_match;
        status[B_EN_VBL]             = en.vbl;
        status[B_EN_HBL]             = en.hbl;
        status[B_EN_MAT]             = en.match;
        status[CMP_LSB +: CMP_W]     = cmp_line;
    end

    // R8: each request lasts a single clock
    a_r8_vbl_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vblank |=> !irq_vblank);
    a_r8_hbl_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hblank |=> !irq_hblank);
    a_r8_mat_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_match |=> !irq_match);
    // R8: a vblank request is followed by a still-active blank
    a_r8_vbl_holds: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vblank |=> in_vblank);
endmodule

// File: rtl/raster_timer.sv
// Module: top of the LCD raster timing generator. Chains the dot prescaler,
// the position counters and the status word, and muxes the register read.
// Assumes V_TOTAL <= 256 so the line fits the 8-bit compare field.
module raster_timer
    import raster_pkg::*;
#(
    parameter int DOT_DIV = 4,
    parameter int H_TOTAL = 308,
    parameter int H_VIS   = 240,
    parameter int V_TOTAL = 228,
    parameter int V_VIS   = 160,
    localparam int HW     = $clog2(H_TOTAL),
    localparam int VW     = $clog2(V_TOTAL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [VW-1:0]    scanline,
    output logic             in_hblank,
    output logic             in_vblank,
    output logic             line_match,
    output logic             irq_vblank,
    output logic             irq_hblank,
    output logic             irq_match
);
    logic             dot_tick;
    logic [HW-1:0]    hpos;
    logic [REG_W-1:0] status;

    raster_dot_div #(.DIV(DOT_DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .dot_tick (dot_tick)
    );

    raster_counters #(
        .H_TOTAL (H_TOTAL),
        .H_VIS   (H_VIS),
        .V_TOTAL (V_TOTAL),
        .V_VIS   (V_VIS)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .dot_tick  (dot_tick),
        .hpos      (hpos),
        .vpos      (scanline),
        .in_hblank (in_hblank),
        .in_vblank (in_vblank)
    );

    raster_status #(.VW(VW)) u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr && !reg_addr),
        .wdata      (reg_wdata),
        .vpos       (scanline),
        .in_hblank  (in_hblank),
        .in_vblank  (in_vblank),
        .status     (status),
        .line_match (line_match),
        .irq_vblank (irq_vblank),
        .irq_hblank (irq_hblank),
        .irq_match  (irq_match)
    );

    // Select the readable register.
    assign reg_rdata = reg_addr ? REG_W'(scanline) : status;

    // R8: a match request only comes with a live match
    a_r8_match_live: assert property (@(posedge clk) disable iff (!rst_n)
        irq_match |-> line_match);
    // R9: no requests in the first clock after reset
    a_r9_quiet_reset: assert property (@(posedge clk)
        !rst_n |=> !(irq_vblank || irq_hblank || irq_match));
endmodule

// File: tb/raster_timer_bench.sv
// Bench: a reduced-size instance compared each clock with a behavioural
// model, plus a default-size instance checked at key cycle counts.
module raster_timer_bench;
    localparam int S_DIV = 4, S_HT = 20, S_HV = 12, S_VT = 10, S_VV = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_addr = 1'b0, reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  scanline;
    logic in_hblank, in_vblank, line_match, irq_vblank, irq_hblank, irq_match;

    logic [15:0] f_rdata;
    logic [7:0]  f_line;
    logic f_hbl, f_vbl, f_mat, f_iv, f_ih, f_im;

    int n_cmp = 0, n_bad = 0;
    int m_div, m_h, m_v, m_cmp, f_k;
    bit m_ev, m_eh, m_em, p_v, p_h, p_m;
    int cnt_iv, cnt_ih, cnt_im;

    always #4 clk = ~clk;

    raster_timer #(.DOT_DIV(S_DIV), .H_TOTAL(S_HT), .H_VIS(S_HV),
                   .V_TOTAL(S_VT), .V_VIS(S_VV)) u_raster_timer (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scanline(scanline),
        .in_hblank(in_hblank), .in_vblank(in_vblank), .line_match(line_match),
        .irq_vblank(irq_vblank), .irq_hblank(irq_hblank), .irq_match(irq_match));

    raster_timer u_full (
        .clk(clk), .rst_n(rst_n), .reg_addr(1'b1), .reg_wr(1'b0),
        .reg_wdata(16'h0), .reg_rdata(f_rdata), .scanline(f_line),
        .in_hblank(f_hbl), .in_vblank(f_vbl), .line_match(f_mat),
        .irq_vblank(f_iv), .irq_hblank(f_ih), .irq_match(f_im));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_status();
        return (m_cmp << 8) | (int'(m_em) << 5) | (int'(m_eh) << 4) | (int'(m_ev) << 3)
             | (int'(m_v == m_cmp) << 2) | (int'(m_h >= S_HV) << 1) | int'(m_v >= S_VV);
    endfunction

    // Behavioural model update at each edge, then compare away from the edge.
    always @(posedge clk) begin
        bit cv, ch, cm;
        cv = (m_v >= S_VV); ch = (m_h >= S_HV); cm = (m_v == m_cmp);
        if (!rst_n) begin
            m_div = 0; m_h = 0; m_v = 0; m_cmp = 0;
            m_ev = 0; m_eh = 0; m_em = 0; p_v = 0; p_h = 0; p_m = 0; f_k = 0;
        end else begin
            p_v = cv; p_h = ch; p_m = cm;
            f_k++;
            if (reg_wr && !reg_addr) begin
                m_ev = reg_wdata[3]; m_eh = reg_wdata[4]; m_em = reg_wdata[5];
                m_cmp = reg_wdata[15:8];
            end
            m_div++;
            if (m_div == S_DIV) begin
                m_div = 0;
                m_h++;
                if (m_h == S_HT) begin
                    m_h = 0;
                    m_v = (m_v + 1) % S_VT;
                end
            end
        end
        #2;
        begin
            bit ev, eh, em;
            ev = m_ev && (m_v >= S_VV) && !p_v;
            eh = m_eh && (m_h >= S_HV) && !p_h;
            em = m_em && (m_v == m_cmp) && !p_m;
            if (!rst_n) begin ev = 0; eh = 0; em = 0; end
            check(int'(scanline) == m_v, "R3 scanline", int'(scanline), m_v);
            check(in_hblank == (m_h >= S_HV), "R2 in_hblank", in_hblank, m_h >= S_HV);
            check(in_vblank == (m_v >= S_VV), "R4 in_vblank", in_vblank, m_v >= S_VV);
            check(line_match == (m_v == m_cmp), "R6 line_match", line_match, m_v == m_cmp);
            check(irq_vblank == ev, "R8 irq_vblank", irq_vblank, ev);
            check(irq_hblank == eh, "R8 irq_hblank", irq_hblank, eh);
            check(irq_match == em, "R8 irq_match", irq_match, em);
            if (reg_addr)
                check(int'(reg_rdata) == m_v, "R5 line read", int'(reg_rdata), m_v);
            else
                check(int'(reg_rdata) == exp_status(), "R6 R7 status read", int'(reg_rdata), exp_status());
            if (rst_n) begin
                cnt_iv += int'(irq_vblank); cnt_ih += int'(irq_hblank); cnt_im += int'(irq_match);
            end
            // R1: default instance, hblank starts at 960 clocks, line 1 at 1232
            if (rst_n && f_k == 959) check(f_hbl == 1'b0, "R1 R2 full hblank before 960", f_hbl, 0);
            if (rst_n && f_k == 960) check(f_hbl == 1'b1, "R1 R2 full hblank at 960", f_hbl, 1);
            if (rst_n && f_k == 1231) check(int'(f_line) == 0, "R1 full line before 1232", f_line, 0);
            if (rst_n && f_k == 1232) begin
                check(int'(f_line) == 1, "R1 full line at 1232", f_line, 1);
                check(f_hbl == 1'b0, "R2 full hblank clears at wrap", f_hbl, 0);
                check(int'(f_rdata) == 1, "R5 full line read", f_rdata, 1);
            end
        end
    end

    task automatic wr_status(input logic [15:0] d);
        @(negedge clk);
        reg_addr = 1'b0; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        cnt_iv = 0; cnt_ih = 0; cnt_im = 0;
        idle(3);
        // R9: reset state with a write attempted under reset
        reg_wr = 1'b1; reg_wdata = 16'hFFFF;
        @(negedge clk);
        reg_wr = 1'b0;
        check(int'(reg_rdata) == 16'h0004, "R9 reset status", int'(reg_rdata), 16'h0004);
        rst_n = 1'b1;
        idle(1400);
        reg_addr = 1'b1; idle(200); reg_addr = 1'b0;
        // R8: enables clear so far, no pulses
        check(cnt_iv + cnt_ih + cnt_im == 0, "R8 no pulse while disabled", cnt_iv + cnt_ih + cnt_im, 0);
        // R7: write ones to flag and spare bits, enable all, compare line 3
        wr_status(16'h03C7 | 16'h0038);
        cnt_iv = 0; cnt_ih = 0; cnt_im = 0;
        idle(2 * S_DIV * S_HT * S_VT);
        check(cnt_iv == 2, "R8 one vblank pulse per frame", cnt_iv, 2);
        check(cnt_ih == 2 * S_VT, "R8 one hblank pulse per line", cnt_ih, 2 * S_VT);
        check(cnt_im == 2, "R8 one match pulse per frame", cnt_im, 2);
        // R7: write to the line register address changes nothing
        @(negedge clk); reg_addr = 1'b1; reg_wr = 1'b1; reg_wdata = 16'h0000;
        @(negedge clk); reg_wr = 1'b0; reg_addr = 1'b0;
        idle(5);
        // R6: move the compare line onto the current line to raise match by write
        wr_status(16'h0020 | (16'(scanline) << 8));
        idle(300);
        // R8: compare outside the frame never matches; only hblank enabled
        wr_status(16'hC810);
        cnt_iv = 0; cnt_ih = 0; cnt_im = 0;
        idle(S_DIV * S_HT * S_VT);
        check(cnt_im == 0 && cnt_iv == 0, "R8 disabled or unmatched stays quiet", cnt_im + cnt_iv, 0);
        check(cnt_ih == S_VT, "R8 hblank pulses with enable", cnt_ih, S_VT);
        // R9: reset mid-frame
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        check(int'(scanline) == 0, "R9 line after reset", int'(scanline), 0);
        rst_n = 1'b1;
        idle(100);
        summary();
    end
endmodule